// File: doc/BRIEF.md
# Authenticated Scratchpad Write Controller

This block sits behind the link layer of a serial memory slave and manages an eight-byte staging buffer that every memory write passes through. The link layer hands it received bytes one at a time, each tagged as complete or partial, and asks it for bytes to send back. Three kinds of transaction are served.

A write (or refresh) carries a two-byte target address and eight data bytes, and is followed by an inverted CRC-16 that the master can read back. A read returns the stored address, a status byte and the eight data bytes, followed by its own inverted CRC-16. A copy raises a one-cycle request toward the downstream memory, but only when an external authorization verdict agrees and the buffer is known to be intact.

The status byte holds two live flags. The partial flag marks a buffer that cannot be trusted. The accepted flag marks a buffer whose contents have already been copied.

The sequencer has these states:
- ST_IDLE: after reset, until the first frame start.
- ST_CMD: waiting for the command byte.
- ST_TA1 and ST_TA2: address low and high bytes.
- ST_WDATA: data bytes.
- ST_WCRC: write CRC readout.
- ST_RD: read readout.
- ST_DONE: the frame is finished and further bytes are ignored.

Its transitions are:
- A frame start moves any state to ST_CMD.
- From ST_CMD, a write or refresh code moves to ST_TA1, a read code moves to ST_RD, and a copy code, any other code or a partial byte moves to ST_DONE.
- ST_TA1 moves to ST_TA2, and ST_TA2 moves to ST_WDATA, each on a complete byte.
- ST_WDATA moves to ST_WCRC after the eighth complete byte.
- A partial byte in ST_TA1, ST_TA2 or ST_WDATA moves to ST_DONE.

Top module: `scratch_wr_ctrl`

## Requirements
- R1: After reset the partial flag is 1, the accepted flag is 0, the stored address is 0 and all eight data bytes are 0, so a read returns 00h, 00h, 7Fh and then eight 00h bytes.
- R2: The stored target address is the address as sent with bits 2:0 forced to 0. A read returns it low byte first.
- R3: Status byte layout: bit 7 is the accepted flag, bit 5 is the partial flag, and bits 6, 4, 3, 2, 1 and 0 always read 1.
- R4: A write with eight complete data bytes stores them at offsets 0 to 7 in arrival order and clears the partial flag.
- R5: A partial byte received after a write or refresh command (in the address or data phase) sets the partial flag and ends the frame. Later bytes in that frame change nothing.
- R6: Write code 0Fh and refresh code 3Ch behave the same way. Each clears the accepted flag once both address bytes have been received.
- R7: After the eighth data byte of a write, the next two transmitted bytes are the low and then the high byte of the complemented CRC-16. The CRC uses the reflected polynomial x^16+x^15+x^2+1, starts at 0, and takes each byte LSB first. It covers the command byte, the address bytes as sent and the data bytes.
- R8: Read code AAh returns the address low byte, the address high byte, the status byte and data bytes 0 to 7. These are followed by the complemented CRC-16 (low byte first) over the command byte and those eleven bytes.
- R9: Copy code 55h with auth_ok high and the partial flag 0 gives a one-cycle copy_req in the cycle after the code. copy_addr and copy_data carry the stored address and buffer, and the accepted flag becomes 1.
- R10: A copy with auth_ok low, or with the partial flag 1, gives no copy_req and leaves the status unchanged.
- R11: frame_start has priority. A received byte or a read request in the same cycle is dropped. Bytes received before the first frame_start after reset are ignored.
- R12: Every rd_req (without frame_start) gives tx_valid in the next cycle. When there is nothing to send, tx_byte is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Start of a new transaction |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_partial | input | 1 | The received byte had fewer than eight bits |
| rd_req | input | 1 | The link layer wants the next byte to send |
| tx_valid | output | 1 | tx_byte is valid (one cycle after rd_req) |
| tx_byte | output | 8 | Byte to send |
| auth_ok | input | 1 | External authorization verdict for a copy |
| copy_req | output | 1 | One-cycle copy request |
| copy_addr | output | 16 | Target address for the copy |
| copy_data | output | 64 | Buffer contents; byte 0 is in bits 7:0 |

## Verification
Two things can fall in the same clock cycle: a frame start and a received byte or read request, and the eighth data byte of a write and a read request. The bench provokes the first by asserting frame_start, rx_valid and rd_req together in the middle of a write. The dropped byte must not appear in the buffer or in the next CRC, and no tx_valid may follow. It provokes the second by asserting the last data byte and rd_req together, and the answer must be FFh, with the CRC bytes coming only on the following requests. A behavioural model built on byte queues predicts tx_valid, tx_byte and copy_req in every cycle, and literal checks on the status byte back it up.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int ADDR_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_TA1,
        ST_TA2,
        ST_WDATA,
        ST_WCRC,
        ST_RD,
        ST_DONE
    } sp_state_e;

    localparam logic [7:0] OP_WRITE   = 8'h0F;
    localparam logic [7:0] OP_REFRESH = 8'h3C;
    localparam logic [7:0] OP_READ    = 8'hAA;
    localparam logic [7:0] OP_COPY    = 8'h55;

    localparam logic [15:0] CRC_REFL_POLY = 16'hA001;

    // one byte through the reflected CRC-16, least significant bit first
    function automatic logic [15:0] crc16_step(input logic [15:0] cur, input logic [7:0] din);
        logic [15:0] c;
        logic        fb;
        c = cur;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ din[i];
            c  = {1'b0, c[15:1]} ^ (fb ? CRC_REFL_POLY : 16'h0000);
        end
        return c;
    endfunction

endpackage

// File: rtl/sp_crc16.sv
module sp_crc16
    import sp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= '0;
        else if (clr)
            crc <= '0;
        else if (en)
            crc <= crc16_step(crc, din);
    end

endmodule

// File: rtl/sp_store.sv
module sp_store
    import sp_pkg::*;
#(
    parameter int NBYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ta_we,
    input  logic [ADDR_W-1:0]     ta_din,
    input  logic                  wr_en,
    input  logic [$clog2(NBYTES)-1:0] wr_idx,
    input  logic [7:0]            wr_data,
    input  logic                  pf_set,
    input  logic                  pf_clr,
    input  logic                  aa_set,
    input  logic                  aa_clr,
    input  logic [$clog2(NBYTES)-1:0] rd_idx,
    output logic [7:0]            rd_data,
    output logic [ADDR_W-1:0]     ta_q,
    output logic [7:0]            es,
    output logic [NBYTES*8-1:0]   buf_flat
);

    localparam int IW = $clog2(NBYTES);

    logic [7:0] bytes_q [NBYTES];
    logic       pf_q;
    logic       aa_q;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bytes_q[g] <= '0;
            else if (wr_en && (wr_idx == IW'(g)))
                bytes_q[g] <= wr_data;
        end
        assign buf_flat[g*8 +: 8] = bytes_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ta_q <= '0;
            pf_q <= 1'b1;
            aa_q <= 1'b0;
        end else begin
            if (ta_we)
                ta_q <= ta_din;
            if (pf_set)
                pf_q <= 1'b1;
            else if (pf_clr)
                pf_q <= 1'b0;
            if (aa_set)
                aa_q <= 1'b1;
            else if (aa_clr)
                aa_q <= 1'b0;
        end
    end

    assign rd_data = bytes_q[rd_idx];
    assign es      = {aa_q, 1'b1, pf_q, 5'b11111};

    // R2
    ta_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ta_q[IW-1:0] == '0);

endmodule

// File: rtl/sp_seq.sv
module sp_seq
    import sp_pkg::*;
#(
    parameter int NBYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic                  rx_partial,
    input  logic                  rd_req,
    input  logic                  auth_ok,
    input  logic [ADDR_W-1:0]     ta_q,
    input  logic [7:0]            es,
    input  logic [7:0]            rd_data,
    input  logic [15:0]           crc,
    output logic                  crc_clr,
    output logic                  crc_en,
    output logic [7:0]            crc_din,
    output logic                  ta_we,
    output logic [ADDR_W-1:0]     ta_din,
    output logic                  wr_en,
    output logic [$clog2(NBYTES)-1:0] wr_idx,
    output logic [7:0]            wr_data,
    output logic                  pf_set,
    output logic                  pf_clr,
    output logic                  aa_set,
    output logic                  aa_clr,
    output logic [$clog2(NBYTES)-1:0] rd_idx,
    output logic                  tx_valid,
    output logic [7:0]            tx_byte,
    output logic                  copy_req
);

    localparam int IW     = $clog2(NBYTES);
    localparam int RD_LEN = 3 + NBYTES + 2;
    localparam int TXW    = $clog2(RD_LEN + 1);
    localparam logic [TXW-1:0] P_TAL  = TXW'(0);
    localparam logic [TXW-1:0] P_TAH  = TXW'(1);
    localparam logic [TXW-1:0] P_ES   = TXW'(2);
    localparam logic [TXW-1:0] P_D0   = TXW'(3);
    localparam logic [TXW-1:0] P_CRCL = TXW'(3 + NBYTES);
    localparam logic [TXW-1:0] P_CRCH = TXW'(4 + NBYTES);
    localparam logic [TXW-1:0] P_END  = TXW'(RD_LEN);
    localparam logic [7:0]     ALIGN_MASK = 8'hFF << IW;

    sp_state_e       state, nxt;
    logic [IW-1:0]   idx;
    logic [TXW-1:0]  pos;
    logic [TXW-1:0]  dpos;
    logic [7:0]      ta1_hold;
    logic [7:0]      tx_next;
    logic            rx_ok, rx_full, rx_part, rdq, copy_go, in_tx;

    assign rx_ok   = rx_valid && !frame_start;
    assign rx_full = rx_ok && !rx_partial;
    assign rx_part = rx_ok && rx_partial;
    assign rdq     = rd_req && !frame_start;
    assign in_tx   = (state == ST_RD) || (state == ST_WCRC);
    assign copy_go = (state == ST_CMD) && rx_full && (rx_data == OP_COPY)
                     && auth_ok && !es[5];

    assign dpos    = pos - P_D0;
    assign rd_idx  = dpos[IW-1:0];
    assign wr_idx  = idx;
    assign wr_data = rx_data;
    assign ta_din  = {rx_data, ta1_hold & ALIGN_MASK};

    // byte offered to the link layer at the current position
    always_comb begin
        tx_next = 8'hFF;
        if (state == ST_RD) begin
            if (pos == P_TAL)
                tx_next = ta_q[7:0];
            else if (pos == P_TAH)
                tx_next = ta_q[15:8];
            else if (pos == P_ES)
                tx_next = es;
            else if (pos >= P_D0 && pos < P_CRCL)
                tx_next = rd_data;
            else if (pos == P_CRCL)
                tx_next = ~crc[7:0];
            else if (pos == P_CRCH)
                tx_next = ~crc[15:8];
        end else if (state == ST_WCRC) begin
            if (pos == P_TAL)
                tx_next = ~crc[7:0];
            else if (pos == P_TAH)
                tx_next = ~crc[15:8];
        end
    end

    // next state and strobes
    always_comb begin
        nxt     = state;
        crc_clr = 1'b0;
        crc_en  = 1'b0;
        crc_din = rx_data;
        ta_we   = 1'b0;
        wr_en   = 1'b0;
        pf_set  = 1'b0;
        pf_clr  = 1'b0;
        aa_set  = copy_go;
        aa_clr  = 1'b0;
        if (frame_start) begin
            nxt     = ST_CMD;
            crc_clr = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE, ST_WCRC: begin
                end
                ST_CMD: begin
                    if (rx_part) begin
                        nxt = ST_DONE;
                    end else if (rx_full) begin
                        crc_en = 1'b1;
                        if (rx_data == OP_WRITE || rx_data == OP_REFRESH)
                            nxt = ST_TA1;
                        else if (rx_data == OP_READ)
                            nxt = ST_RD;
                        else
                            nxt = ST_DONE;
                    end
                end
                ST_TA1: begin
                    if (rx_part) begin
                        pf_set = 1'b1;
                        nxt    = ST_DONE;
                    end else if (rx_full) begin
                        crc_en = 1'b1;
                        nxt    = ST_TA2;
                    end
                end
                ST_TA2: begin
                    if (rx_part) begin
                        pf_set = 1'b1;
                        nxt    = ST_DONE;
                    end else if (rx_full) begin
                        crc_en = 1'b1;
                        ta_we  = 1'b1;
                        aa_clr = 1'b1;
                        nxt    = ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (rx_part) begin
                        pf_set = 1'b1;
                        nxt    = ST_DONE;
                    end else if (rx_full) begin
                        crc_en = 1'b1;
                        wr_en  = 1'b1;
                        if (idx == IW'(NBYTES - 1)) begin
                            pf_clr = 1'b1;
                            nxt    = ST_WCRC;
                        end
                    end
                end
                ST_RD: begin
                    if (rdq && pos < P_CRCL) begin
                        crc_en  = 1'b1;
                        crc_din = tx_next;
                    end
                end
            endcase
        end
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            pos      <= '0;
            ta1_hold <= '0;
        end else begin
            state <= nxt;
            if (frame_start) begin
                idx <= '0;
                pos <= '0;
            end else begin
                if (wr_en)
                    idx <= idx + 1'b1;
                if (rdq && in_tx && pos != P_END)
                    pos <= pos + 1'b1;
                if (state == ST_TA1 && rx_full)
                    ta1_hold <= rx_data;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= 8'hFF;
            copy_req <= 1'b0;
        end else begin
            tx_valid <= rdq;
            if (rdq)
                tx_byte <= tx_next;
            copy_req <= copy_go;
        end
    end

    // R12
    tx_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !frame_start) |=> tx_valid);

    // R12
    tx_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(rd_req && !frame_start));

    // R10
    copy_needs_auth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req |-> $past(auth_ok) && !$past(es[5]));

    // R11
    frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> state == ST_CMD);

    // R5
    partial_ends_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_part && (state == ST_TA1 || state == ST_TA2 || state == ST_WDATA))
        |=> (state == ST_DONE && es[5]));

    // R4
    full_write_clears_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WDATA && state == ST_WCRC) |-> !es[5]);

endmodule

// File: rtl/scratch_wr_ctrl.sv
module scratch_wr_ctrl
    import sp_pkg::*;
#(
    parameter int NBYTES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                rx_valid,
    input  logic [7:0]          rx_data,
    input  logic                rx_partial,
    input  logic                rd_req,
    output logic                tx_valid,
    output logic [7:0]          tx_byte,
    input  logic                auth_ok,
    output logic                copy_req,
    output logic [15:0]         copy_addr,
    output logic [NBYTES*8-1:0] copy_data
);

    localparam int IW = $clog2(NBYTES);

    logic              crc_clr, crc_en;
    logic [7:0]        crc_din;
    logic [15:0]       crc;
    logic              ta_we, wr_en, pf_set, pf_clr, aa_set, aa_clr;
    logic [ADDR_W-1:0] ta_din, ta_q;
    logic [IW-1:0]     wr_idx, rd_idx;
    logic [7:0]        wr_data, rd_data, es;

    sp_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (crc_din),
        .crc   (crc)
    );

    sp_store #(.NBYTES(NBYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ta_we    (ta_we),
        .ta_din   (ta_din),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .pf_set   (pf_set),
        .pf_clr   (pf_clr),
        .aa_set   (aa_set),
        .aa_clr   (aa_clr),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .ta_q     (ta_q),
        .es       (es),
        .buf_flat (copy_data)
    );

    sp_seq #(.NBYTES(NBYTES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_partial  (rx_partial),
        .rd_req      (rd_req),
        .auth_ok     (auth_ok),
        .ta_q        (ta_q),
        .es          (es),
        .rd_data     (rd_data),
        .crc         (crc),
        .crc_clr     (crc_clr),
        .crc_en      (crc_en),
        .crc_din     (crc_din),
        .ta_we       (ta_we),
        .ta_din      (ta_din),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .pf_set      (pf_set),
        .pf_clr      (pf_clr),
        .aa_set      (aa_set),
        .aa_clr      (aa_clr),
        .rd_idx      (rd_idx),
        .tx_valid    (tx_valid),
        .tx_byte     (tx_byte),
        .copy_req    (copy_req)
    );

    assign copy_addr = ta_q;

    // R9
    copy_sets_aa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req |-> es[7]);

endmodule

// File: tb/scratch_wr_ctrl_test.sv
`timescale 1ns/1ps
module scratch_wr_ctrl_test;

    localparam logic [7:0] C_WR = 8'h0F, C_RF = 8'h3C, C_RD = 8'hAA, C_CP = 8'h55;
    localparam int M_IDLE = 0, M_CMD = 1, M_TA1 = 2, M_TA2 = 3, M_DAT = 4, M_WCRC = 5, M_RD = 6, M_DONE = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0, rx_valid = 1'b0, rx_partial = 1'b0, rd_req = 1'b0, auth_ok = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        tx_valid, copy_req;
    logic [7:0]  tx_byte;
    logic [15:0] copy_addr;
    logic [63:0] copy_data;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // model state
    bit          m_pf, m_aa;
    logic [15:0] m_ta;
    logic [7:0]  m_ta1;
    logic [7:0]  m_buf [8];
    int          m_mode, m_idx;
    logic [15:0] m_crc;
    logic [7:0]  txq [$];
    logic [7:0]  got_q [$];
    bit          e_txv, e_cp;
    logic [7:0]  e_txb;
    logic [15:0] e_addr;
    logic [63:0] e_data;

    always #2 clk = ~clk;

    scratch_wr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_partial(rx_partial), .rd_req(rd_req),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .auth_ok(auth_ok),
        .copy_req(copy_req), .copy_addr(copy_addr), .copy_data(copy_data)
    );

    function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] != b[i]) r = (r >> 1) ^ 16'hA001;
            else              r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] m_es();
        return {m_aa, 1'b1, m_pf, 5'h1F};
    endfunction

    function automatic logic [63:0] m_flat();
        logic [63:0] f;
        for (int i = 0; i < 8; i++) f[i*8 +: 8] = m_buf[i];
        return f;
    endfunction

    task automatic model_rx(input logic [7:0] b, input bit part, input bit au);
        logic [7:0] resp [$];
        if (m_mode == M_CMD) begin
            if (part) m_mode = M_DONE;
            else begin
                m_crc = bcrc(m_crc, b);
                if (b == C_WR || b == C_RF) m_mode = M_TA1;
                else if (b == C_RD) begin
                    resp = {m_ta[7:0], m_ta[15:8], m_es()};
                    for (int i = 0; i < 8; i++) resp.push_back(m_buf[i]);
                    foreach (resp[i]) begin
                        m_crc = bcrc(m_crc, resp[i]);
                        txq.push_back(resp[i]);
                    end
                    txq.push_back(~m_crc[7:0]);
                    txq.push_back(~m_crc[15:8]);
                    m_mode = M_RD;
                end else begin
                    if (b == C_CP && au && !m_pf) begin
                        e_cp = 1'b1; e_addr = m_ta; e_data = m_flat(); m_aa = 1'b1;
                    end
                    m_mode = M_DONE;
                end
            end
        end else if (m_mode == M_TA1 || m_mode == M_TA2 || m_mode == M_DAT) begin
            if (part) begin
                m_pf = 1'b1; m_mode = M_DONE;
            end else begin
                m_crc = bcrc(m_crc, b);
                if (m_mode == M_TA1) begin
                    m_ta1 = b; m_mode = M_TA2;
                end else if (m_mode == M_TA2) begin
                    m_ta = {b, m_ta1 & 8'hF8}; m_aa = 1'b0; m_idx = 0; m_mode = M_DAT;
                end else begin
                    m_buf[m_idx] = b; m_idx++;
                    if (m_idx == 8) begin
                        m_pf = 1'b0;
                        txq.push_back(~m_crc[7:0]);
                        txq.push_back(~m_crc[15:8]);
                        m_mode = M_WCRC;
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pf = 1'b1; m_aa = 1'b0; m_ta = '0; m_ta1 = '0; m_mode = M_IDLE; m_idx = 0;
            m_crc = '0; txq.delete(); e_txv = 1'b0; e_cp = 1'b0; e_txb = 8'hFF;
            for (int i = 0; i < 8; i++) m_buf[i] = 8'h00;
        end else begin
            e_txv = 1'b0; e_cp = 1'b0;
            if (frame_start) begin
                m_mode = M_CMD; m_crc = '0; txq.delete();
            end else begin
                if (rd_req) begin
                    e_txv = 1'b1;
                    e_txb = (txq.size() > 0) ? txq.pop_front() : 8'hFF;
                end
                if (rx_valid) model_rx(rx_data, rx_partial, auth_ok);
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1", "tx_valid in reset", {63'd0, tx_valid}, 64'd0);
            chk("R1", "copy_req in reset", {63'd0, copy_req}, 64'd0);
        end else begin
            chk(cur_req, "tx_valid", {63'd0, tx_valid}, {63'd0, e_txv});
            if (e_txv) chk(cur_req, "tx_byte", {56'd0, tx_byte}, {56'd0, e_txb});
            chk(cur_req, "copy_req", {63'd0, copy_req}, {63'd0, e_cp});
            if (e_cp) begin
                chk(cur_req, "copy_addr", {48'd0, copy_addr}, {48'd0, e_addr});
                chk(cur_req, "copy_data", copy_data, e_data);
            end
            if (tx_valid) got_q.push_back(tx_byte);
        end
    end

    task automatic step(input bit fs, input bit rv, input bit pt, input logic [7:0] d, input bit rr, input bit au);
        @(negedge clk);
        frame_start = fs; rx_valid = rv; rx_partial = pt; rx_data = d; rd_req = rr; auth_ok = au;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 0, 0);
    endtask

    task automatic rx(input logic [7:0] d);
        step(0, 1, 0, d, 0, 0);
    endtask

    task automatic read_sp();
        got_q.delete();
        step(1, 0, 0, 8'h00, 0, 0);
        rx(C_RD);
        for (int i = 0; i < 13; i++) step(0, 0, 0, 8'h00, 1, 0);
        idle(2);
    endtask

    task automatic write_sp(input logic [7:0] op, input logic [15:0] a, input logic [63:0] d);
        step(1, 0, 0, 8'h00, 0, 0);
        rx(op); rx(a[7:0]); rx(a[15:8]);
        for (int i = 0; i < 8; i++) rx(d[i*8 +: 8]);
        got_q.delete();
        for (int i = 0; i < 3; i++) step(0, 0, 0, 8'h00, 1, 0);
        idle(2);
    endtask

    task automatic copy_sp(input bit au);
        step(1, 0, 0, 8'h00, 0, 0);
        step(0, 1, 0, C_CP, 0, au);
        idle(3);
    endtask

    task automatic lit(input string req, input int i, input logic [7:0] exp);
        if (got_q.size() > i) chk(req, "read byte", {56'd0, got_q[i]}, {56'd0, exp});
        else chk(req, "read byte missing", 64'd0, {56'd0, exp});
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R11: bytes before the first frame start are ignored
        cur_req = "R11";
        rx(C_RD);
        step(0, 0, 0, 8'h00, 1, 0);
        idle(2);

        // R1 / R3 / R8: reset contents
        cur_req = "R1";
        read_sp();
        lit("R1", 0, 8'h00); lit("R1", 1, 8'h00); lit("R3", 2, 8'h7F); lit("R1", 3, 8'h00);

        // R2 / R4 / R7 / R12: full write with address low bits set
        cur_req = "R7";
        write_sp(C_WR, 16'h0137, 64'h8877_6655_4433_2211);
        lit("R12", 2, 8'hFF);

        cur_req = "R8";
        read_sp();
        lit("R2", 0, 8'h30); lit("R2", 1, 8'h01); lit("R4", 2, 8'h5F);
        lit("R4", 3, 8'h11); lit("R4", 10, 8'h88);

        // R10 then R9: copy refused, then accepted
        cur_req = "R10";
        copy_sp(1'b0);
        read_sp();
        lit("R10", 2, 8'h5F);
        cur_req = "R9";
        copy_sp(1'b1);
        read_sp();
        lit("R9", 2, 8'hDF);

        // R6: refresh clears the accepted flag
        cur_req = "R6";
        write_sp(C_RF, 16'hA5FF, 64'h0102_0304_0506_0708);
        read_sp();
        lit("R6", 2, 8'h5F); lit("R6", 0, 8'hF8); lit("R6", 1, 8'hA5);

        // R5: partial data byte
        cur_req = "R5";
        step(1, 0, 0, 8'h00, 0, 0);
        rx(C_WR); rx(8'h40); rx(8'h00);
        rx(8'hC1); rx(8'hC2); rx(8'hC3);
        step(0, 1, 1, 8'hC4, 0, 0);
        rx(8'hC5); rx(8'hC6);
        step(0, 0, 0, 8'h00, 1, 0);
        idle(2);
        read_sp();
        lit("R5", 2, 8'h7F); lit("R5", 0, 8'h40); lit("R5", 5, 8'hC3); lit("R5", 6, 8'h05);
        cur_req = "R10";
        copy_sp(1'b1);
        read_sp();
        lit("R10", 2, 8'h7F);

        // R5: partial address byte
        cur_req = "R5";
        write_sp(C_WR, 16'h1020, 64'h0);
        step(1, 0, 0, 8'h00, 0, 0);
        rx(C_WR); step(0, 1, 1, 8'h77, 0, 0); rx(8'h99);
        idle(2);
        read_sp();
        lit("R5", 2, 8'h7F); lit("R5", 0, 8'h20);

        // R11: frame start colliding with a byte and a read request
        cur_req = "R11";
        step(1, 0, 0, 8'h00, 0, 0);
        rx(C_WR); rx(8'h08); rx(8'h02); rx(8'hE0); rx(8'hE1);
        step(1, 1, 0, C_RD, 1, 0);
        rx(C_WR); rx(8'h10); rx(8'h03);
        for (int i = 0; i < 7; i++) rx(8'hD0 + 8'(i));
        // R7: last data byte together with a read request
        cur_req = "R7";
        step(0, 1, 0, 8'hD7, 1, 0);
        got_q.delete();
        step(0, 0, 0, 8'h00, 1, 0);
        step(0, 0, 0, 8'h00, 1, 0);
        idle(2);
        cur_req = "R8";
        read_sp();
        lit("R11", 0, 8'h10); lit("R11", 1, 8'h03); lit("R11", 3, 8'hD0); lit("R4", 2, 8'h5F);

        // R9: copy of the new contents, back-to-back requests across frames
        cur_req = "R9";
        copy_sp(1'b1);
        read_sp();
        lit("R9", 2, 8'hDF);

        idle(3);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule